// File: doc/BRIEF.md
# Range Translation Cache

This block is a small, fully associative cache of range translations that sits beside the second-level page TLB. It is probed after a first-level TLB miss. Each entry maps a contiguous span of virtual page numbers, bounded by an inclusive lower and upper page number, onto an equally contiguous span of physical pages. It also carries one protection value for the whole span. A virtual page number that falls inside a valid entry's span is translated by adding that entry's signed offset. The result is the physical page number for a single-page refill of the first-level data TLB, sent out together with the entry's protection bits.

A lookup answers one cycle later through registered outputs. A miss raises a walk request for the page table walker. New ranges arrive over a refill port after a range table walk finishes elsewhere. A refill goes into the lowest free slot, or into a round-robin victim once every slot is in use. A flush input invalidates every entry at one clock edge. Pages are 4 KB and virtual addresses are 48 bits, so page numbers are 36 bits wide by default.

Top module: `range_tlb`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_walk are 0 and every entry is invalid, so the first lookup misses.
- R2: An entry matches a lookup page number v when the entry is valid and fill_base <= v <= fill_limit, with both bounds included and compared as unsigned values. Page numbers outside the span do not match.
- R3: On a hit, rsp_ppn equals the lookup page number plus the entry's offset, modulo 2^VPN_W. The offset is two's complement, so it can move the span up or down. rsp_prot equals the entry's protection value unchanged.
- R4: A lookup presented with lk_valid high at a clock edge produces rsp_valid high for exactly the following cycle, with that lookup's result. rsp_valid is low in every cycle that does not follow a lookup.
- R5: When rsp_valid is high and no entry matched, rsp_walk is 1, rsp_hit is 0, and rsp_ppn and rsp_prot are 0. On a hit, rsp_walk is 0. Outside rsp_valid, both rsp_hit and rsp_walk are 0.
- R6: When several valid entries match, the one with the lowest slot index supplies the translation.
- R7: A refill is written into the lowest-indexed invalid slot when one exists, so refills after a reset or a flush fill slots 0, 1, 2 and so on in order.
- R8: A refill into a full table replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping after the last slot, on each such replacement.
- R9: A flush invalidates all entries at that clock edge. A refill presented in the same cycle as a flush is discarded.
- R10: A lookup presented in the same cycle as a refill or a flush is answered from the table contents held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fill_valid | input | 1 | Install a range entry |
| fill_base | input | VPN_W | First virtual page of the range |
| fill_limit | input | VPN_W | Last virtual page of the range (inclusive) |
| fill_offset | input | VPN_W | Two's complement physical minus virtual page distance |
| fill_prot | input | PROT_W | Protection value for the range |
| flush | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup matched a range |
| rsp_walk | output | 1 | Lookup missed; page walk needed |
| rsp_ppn | output | VPN_W | Physical page number for the first-level refill |
| rsp_prot | output | PROT_W | Protection bits of the matching range |

## Verification
The assertions assume that reset is held for at least one edge. They also assume that fill_valid and flush are single-cycle pulses that the environment drives cleanly, so the slot-count properties can count how valid bits change from edge to edge. The directed stimulus keeps every installed range well formed, with base no greater than limit. It creates overlaps only in the scenario that tests priority. All inputs change on the falling clock edge, so each fill, flush and lookup is seen at exactly one rising edge, as the properties expect.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

   // Index width for a table of n slots, never below one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // True when n is a power of two, used to pick the pointer wrap variant.
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/range_tlb_prio.sv
module range_tlb_prio #(
   parameter int unsigned N  = 32,
   parameter int unsigned IW = 5
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("range_tlb_prio: N must be at least 2");
   end

   // Scan downward so the lowest set request is the last one written.
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/range_tlb_slot.sv
module range_tlb_slot #(
   parameter int unsigned VPN_W  = 36,
   parameter int unsigned PROT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [VPN_W-1:0]  wr_base,
   input  logic [VPN_W-1:0]  wr_limit,
   input  logic [VPN_W-1:0]  wr_off,
   input  logic [PROT_W-1:0] wr_prot,
   input  logic [VPN_W-1:0]  probe_vpn,
   output logic              live,
   output logic              match,
   output logic [VPN_W-1:0]  off,
   output logic [PROT_W-1:0] prot
);
   logic [VPN_W-1:0] lo_q;
   logic [VPN_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live <= 1'b0;
         lo_q <= '0;
         hi_q <= '0;
         off  <= '0;
         prot <= '0;
      end else if (clr) begin
         live <= 1'b0;
      end else if (wr_en) begin
         live <= 1'b1;
         lo_q <= wr_base;
         hi_q <= wr_limit;
         off  <= wr_off;
         prot <= wr_prot;
      end
   end

   // Inclusive interval compare on both bounds.
   assign match = live && (probe_vpn >= lo_q) && (probe_vpn <= hi_q);
endmodule

// File: rtl/range_tlb_victim.sv
module range_tlb_victim #(
   parameter int unsigned N  = 32,
   parameter int unsigned IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  live,
   input  logic          install,
   output logic [IW-1:0] slot
);
   import range_tlb_pkg::*;

   logic          free_any;
   logic [IW-1:0] free_idx;
   logic [IW-1:0] rr_q;
   logic [IW-1:0] rr_next;

   range_tlb_prio #(.N(N), .IW(IW)) u_free (
      .req (~live),
      .any (free_any),
      .idx (free_idx)
   );

   if (is_pow2(N)) begin : g_wrap_pow2
      assign rr_next = rr_q + IW'(1);
   end else begin : g_wrap_cmp
      assign rr_next = (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rr_q <= '0;
      else if (install && !free_any) rr_q <= rr_next;
   end

   assign slot = free_any ? free_idx : rr_q;
endmodule

// File: rtl/range_tlb.sv
module range_tlb #(
   parameter int unsigned VPN_W   = 36,
   parameter int unsigned PROT_W  = 4,
   parameter int unsigned ENTRIES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_base,
   input  logic [VPN_W-1:0]  fill_limit,
   input  logic [VPN_W-1:0]  fill_offset,
   input  logic [PROT_W-1:0] fill_prot,
   input  logic              flush,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_walk,
   output logic [VPN_W-1:0]  rsp_ppn,
   output logic [PROT_W-1:0] rsp_prot
);
   import range_tlb_pkg::*;

   localparam int unsigned IW = idx_width(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("range_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W < 8) begin : g_bad_vpn
      $error("range_tlb: VPN_W must be at least 8");
   end
   if (PROT_W < 1) begin : g_bad_prot
      $error("range_tlb: PROT_W must be at least 1");
   end

   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_match;
   logic [ENTRIES-1:0] ent_wr;
   logic [VPN_W-1:0]   ent_off  [ENTRIES];
   logic [PROT_W-1:0]  ent_prot [ENTRIES];
   logic [IW-1:0]      fill_slot;
   logic               install;
   logic               hit_any;
   logic [IW-1:0]      hit_idx;
   logic [VPN_W-1:0]   sum_ppn;

   // Flush dominates a refill in the same cycle.
   assign install = fill_valid && !flush;

   range_tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .live    (ent_valid),
      .install (install),
      .slot    (fill_slot)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign ent_wr[g] = install && (fill_slot == IW'(g));

      range_tlb_slot #(.VPN_W(VPN_W), .PROT_W(PROT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (flush),
         .wr_en     (ent_wr[g]),
         .wr_base   (fill_base),
         .wr_limit  (fill_limit),
         .wr_off    (fill_offset),
         .wr_prot   (fill_prot),
         .probe_vpn (lk_vpn),
         .live      (ent_valid[g]),
         .match     (ent_match[g]),
         .off       (ent_off[g]),
         .prot      (ent_prot[g])
      );
   end

   range_tlb_prio #(.N(ENTRIES), .IW(IW)) u_hit (
      .req (ent_match),
      .any (hit_any),
      .idx (hit_idx)
   );

   // Modulo 2^VPN_W add; the offset is two's complement.
   assign sum_ppn = lk_vpn + ent_off[hit_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_walk  <= 1'b0;
         rsp_ppn   <= '0;
         rsp_prot  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && hit_any;
         rsp_walk  <= lk_valid && !hit_any;
         rsp_ppn   <= (lk_valid && hit_any) ? sum_ppn : '0;
         rsp_prot  <= (lk_valid && hit_any) ? ent_prot[hit_idx] : '0;
      end
   end
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
   parameter int unsigned N = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         lk_valid,
   input logic         fill_valid,
   input logic         flush,
   input logic         rsp_valid,
   input logic         rsp_hit,
   input logic         rsp_walk,
   input logic [N-1:0] ent_valid
);
   // R4
   resp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   // R4
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   // R5
   hit_walk_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_walk) |-> (rsp_valid && (rsp_hit != rsp_walk)));

   // R9
   flush_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ent_valid == '0));

   // R9
   flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush ##1 lk_valid) |=> !rsp_hit);

   // R7
   fill_takes_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush && !(&ent_valid)) |=>
         ($countones(ent_valid) == $past($countones(ent_valid)) + 1));

   // R8
   full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush && (&ent_valid)) |=> (&ent_valid));
endmodule

bind range_tlb range_tlb_chk #(.N(ENTRIES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .fill_valid (fill_valid),
   .flush      (flush),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_walk   (rsp_walk),
   .ent_valid  (ent_valid)
);

// File: tb/range_tlb_test.sv
`timescale 1ns/1ps
module range_tlb_test;
   localparam int unsigned VW = 36;
   localparam int unsigned PW = 4;
   localparam int unsigned NE = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic          fill_valid = 1'b0;
   logic [VW-1:0] fill_base = '0;
   logic [VW-1:0] fill_limit = '0;
   logic [VW-1:0] fill_offset = '0;
   logic [PW-1:0] fill_prot = '0;
   logic          flush = 1'b0;
   logic          rsp_valid, rsp_hit, rsp_walk;
   logic [VW-1:0] rsp_ppn;
   logic [PW-1:0] rsp_prot;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   range_tlb #(.VPN_W(VW), .PROT_W(PW), .ENTRIES(NE)) uut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
      .fill_valid(fill_valid), .fill_base(fill_base), .fill_limit(fill_limit),
      .fill_offset(fill_offset), .fill_prot(fill_prot), .flush(flush),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_walk(rsp_walk),
      .rsp_ppn(rsp_ppn), .rsp_prot(rsp_prot)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic install(input logic [VW-1:0] b, input logic [VW-1:0] l,
                          input logic [VW-1:0] o, input logic [PW-1:0] p);
      @(negedge clk);
      fill_valid = 1'b1; fill_base = b; fill_limit = l; fill_offset = o; fill_prot = p;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   // Present one lookup and compare the registered response one edge later.
   task automatic probe(input logic [VW-1:0] v, input bit exp_hit,
                        input logic [VW-1:0] exp_ppn, input logic [PW-1:0] exp_prot,
                        input string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = v;
      @(negedge clk);
      lk_valid = 1'b0;
      check(rsp_valid && rsp_hit == exp_hit && rsp_walk == !exp_hit,
            {req, " hit/walk"}, {rsp_valid, rsp_hit, rsp_walk}, {1'b1, exp_hit, !exp_hit});
      check(rsp_ppn == (exp_hit ? exp_ppn : '0), {req, " ppn"}, rsp_ppn, exp_hit ? exp_ppn : 0);
      check(rsp_prot == (exp_hit ? exp_prot : '0), {req, " prot"}, rsp_prot, exp_hit ? exp_prot : 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(!rsp_valid && !rsp_hit && !rsp_walk, "R1 outputs idle in reset",
            {rsp_valid, rsp_hit, rsp_walk}, 0);
      rst_n = 1'b1;
      probe(36'h0, 1'b0, '0, '0, "R1 empty table misses");
      @(negedge clk);
      check(!rsp_valid && !rsp_walk, "R4 single response cycle", {rsp_valid, rsp_walk}, 0);
   endtask

   task automatic t_bounds();
      install(36'h100, 36'h1FF, 36'h1000, 4'h5);
      probe(36'h100, 1'b1, 36'h1100, 4'h5, "R2 base inclusive");
      probe(36'h1FF, 1'b1, 36'h11FF, 4'h5, "R2 limit inclusive");
      probe(36'h200, 1'b0, '0, '0, "R2/R5 above limit");
      probe(36'h0FF, 1'b0, '0, '0, "R2/R5 below base");
   endtask

   task automatic t_offsets();
      install(36'hFFFFFFFF0, 36'hFFFFFFFFF, 36'h20, 4'h3);
      probe(36'hFFFFFFFF8, 1'b1, 36'h18, 4'h3, "R3 wrapping add");
      install(36'h5000, 36'h5000, 36'hFFFFFC000, 4'hA);
      probe(36'h5000, 1'b1, 36'h1000, 4'hA, "R3 negative offset single page");
      probe(36'h5001, 1'b0, '0, '0, "R2 one past single page");
   endtask

   task automatic t_priority();
      // Slots 0..2 are taken, so this range lands in slot 3 (R7).
      install(36'h150, 36'h160, 36'h7, 4'h1);
      probe(36'h155, 1'b1, 36'h1155, 4'h5, "R6 lowest slot wins overlap");
      probe(36'h158 + 36'h8, 1'b1, 36'h1160, 4'h5, "R6 lowest slot at shared limit");
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = 36'h305;
      fill_valid = 1'b1; fill_base = 36'h300; fill_limit = 36'h30F;
      fill_offset = 36'h40; fill_prot = 4'h6;
      @(negedge clk);
      lk_valid = 1'b0; fill_valid = 1'b0;
      check(rsp_valid && !rsp_hit && rsp_walk, "R10 lookup beside refill sees old table",
            {rsp_valid, rsp_hit, rsp_walk}, 3'b101);
      probe(36'h305, 1'b1, 36'h345, 4'h6, "R10 refill visible next cycle");
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = 36'h100; flush = 1'b1;
      fill_valid = 1'b1; fill_base = 36'h800; fill_limit = 36'h8FF;
      fill_offset = 36'h1; fill_prot = 4'h2;
      @(negedge clk);
      lk_valid = 1'b0; flush = 1'b0; fill_valid = 1'b0;
      check(rsp_hit && rsp_ppn == 36'h1100, "R10 lookup beside flush sees old table", rsp_ppn, 36'h1100);
      probe(36'h100, 1'b0, '0, '0, "R9 flushed range misses");
      probe(36'h305, 1'b0, '0, '0, "R9 second flushed range misses");
      probe(36'h850, 1'b0, '0, '0, "R9 refill with flush discarded");
   endtask

   task automatic t_replace();
      for (int i = 0; i < NE; i++)
         install(VW'(i) * 36'h100, VW'(i) * 36'h100 + 36'hF, 36'h10000, PW'(i));
      probe(36'h505, 1'b1, 36'h10505, 4'h5, "R7 in-order fill slot 5");
      install(36'h900000, 36'h900FFF, 36'h0, 4'hF);
      probe(36'h000005, 1'b0, '0, '0, "R8 first victim is slot 0");
      probe(36'h105, 1'b1, 36'h10105, 4'h1, "R8 slot 1 kept");
      probe(36'h900010, 1'b1, 36'h900010, 4'hF, "R8 new range hits");
      install(36'hA00000, 36'hA00000, 36'h1, 4'hE);
      probe(36'h105, 1'b0, '0, '0, "R8 pointer advanced to slot 1");
      probe(36'h205, 1'b1, 36'h10205, 4'h2, "R8 slot 2 kept");
      do_flush();
      install(36'h40, 36'h4F, 36'h3, 4'h7);
      install(36'h40, 36'h4F, 36'h9, 4'h8);
      probe(36'h44, 1'b1, 36'h47, 4'h7, "R7 after flush refill restarts at slot 0");
   endtask

   initial begin
      t_reset();
      t_bounds();
      t_offsets();
      t_priority();
      t_same_cycle();
      t_replace();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule